// File: doc/BRIEF.md
# Coprocessor Register Access Decoder

This block sits beside a processor core's execute stage and services register-transfer instructions aimed at coprocessors. Each request presents the 32-bit instruction word, a direction strobe, write data and the core's running cycle count. The block pulls the coprocessor and register numbers out of the instruction word. It holds the system coprocessor's control word and translation table base. It returns read data one cycle later, together with either a completion pulse or a fault pulse.

The system coprocessor (number 15) provides an identification word, the control word and the table base. Its cache-maintenance and TLB-maintenance registers accept writes and do nothing with them. The debug coprocessor (number 14) is present only while the extended-architecture input is high. It returns the live cycle count from its register 1 and discards every write. Any other coprocessor number faults.

The MMU-enable bit (control bit 0) and the table base leave the block as ports for the address translation logic. A three-state machine drives the response: ST_IDLE when no request was seen in the previous cycle, ST_ACK after a serviced request, and ST_FAULT after an unsupported one. From any state, a request moves it to ST_ACK or ST_FAULT, and a cycle without a request moves it to ST_IDLE.

Top module: `cpx_access`

## Requirements
- R1: The coprocessor number is taken from instruction bits [11:8] and the register number from bits [19:16]. All other instruction bits are ignored.
- R2: After reset the stored control word and table base are zero, so mmu_on and table_base are 0. done, err and rdata are 0.
- R3: A write to coprocessor 15 register 1 stores wdata AND CTRL_WMASK. mmu_on follows stored bit 0. A read of that register returns the stored word ORed with 0x70, so bits 6:4 always read as one.
- R4: A write to coprocessor 15 register 2 stores the full wdata. It is visible on table_base the cycle after the request, and a read returns it.
- R5: A read of coprocessor 15 register 0 returns the ID_VALUE parameter. Reads of coprocessor 15 registers other than 0, 1 and 2 return zero.
- R6: Writes to coprocessor 15 registers other than 1 and 2, including 7 (cache operations) and 8 (TLB operations), complete with done and change no state.
- R7: With ext_en high, a read of coprocessor 14 register 1 returns the cycle_count value present in the request cycle. Reads of other coprocessor 14 registers return zero.
- R8: With ext_en high, writes to coprocessor 14 complete with done and change no state.
- R9: A request to any coprocessor other than 14 or 15, or to 14 with ext_en low, gives err instead of done, rdata 0, and no state change.
- R10: The cycle after a request, exactly one of done and err is high. The cycle after a cycle without a request, both are low. Requests may be back to back. rdata is zero for write responses and for cycles without a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request this cycle |
| wr | input | 1 | 1 = write to coprocessor, 0 = read |
| insn | input | 32 | Register-transfer instruction word |
| wdata | input | 32 | Data written on a write request |
| cycle_count | input | 32 | Free-running cycle count of the core |
| ext_en | input | 1 | Extended architecture present (enables coprocessor 14) |
| rdata | output | 32 | Read result, valid with done |
| done | output | 1 | Request serviced (one cycle after req) |
| err | output | 1 | Request faulted (one cycle after req) |
| mmu_on | output | 1 | Control bit 0, the MMU enable |
| table_base | output | 32 | Stored translation table base |

## Verification
A corrupt control word or table base shows on mmu_on or table_base in the cycle after the write that caused it. The bench compares both ports after every access, so a stray write from a maintenance register, the debug coprocessor or a faulting request is caught within one cycle. A decode fault in the coprocessor or register field shows as a wrong done/err choice or wrong rdata in the response cycle. The bench sweeps every coprocessor and register number, with ext_en both low and high, so such a fault is seen on the first access that reaches the misdecoded case. A stuck response state shows on done/err in the idle cycle that follows each access.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    localparam int INSN_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACK   = 2'd1,
        ST_FAULT = 2'd2
    } cpx_state_e;

    localparam logic [3:0] CP_SYS   = 4'd15;
    localparam logic [3:0] CP_DBG   = 4'd14;
    localparam logic [3:0] RN_ID    = 4'd0;
    localparam logic [3:0] RN_CTRL  = 4'd1;
    localparam logic [3:0] RN_TTB   = 4'd2;
    localparam logic [3:0] RN_CYCLE = 4'd1;

    localparam logic [31:0] CTRL_READ_ONES = 32'h0000_0070;

endpackage

// File: rtl/cpx_decode.sv
module cpx_decode
    import cpx_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter logic [31:0] ID_VALUE = 32'h6905_2100
) (
    input  logic [INSN_W-1:0] insn,
    input  logic              ext_en,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] ttb_q,
    input  logic [DATA_W-1:0] cycle_count,
    output logic              fault,
    output logic              sys_sel,
    output logic [3:0]        crn,
    output logic [DATA_W-1:0] rd_value
);
    logic [3:0] cpn;
    logic       dbg_sel;
    logic       unused_insn_bits;

    assign cpn              = insn[11:8];
    assign crn              = insn[19:16];
    assign unused_insn_bits = ^{insn[31:20], insn[15:12], insn[7:0]};

    assign sys_sel = (cpn == CP_SYS);
    assign dbg_sel = (cpn == CP_DBG) && ext_en;
    assign fault   = !(sys_sel || dbg_sel);

    always_comb begin
        rd_value = '0;
        if (sys_sel) begin
            unique case (crn)
                RN_ID:   rd_value = DATA_W'(ID_VALUE);
                RN_CTRL: rd_value = ctrl_q | DATA_W'(CTRL_READ_ONES);
                RN_TTB:  rd_value = ttb_q;
                default: rd_value = '0;
            endcase
        end else if (dbg_sel) begin
            rd_value = (crn == RN_CYCLE) ? cycle_count : '0;
        end
    end
endmodule

// File: rtl/cpx_regfile.sv
module cpx_regfile #(
    parameter int          DATA_W     = 32,
    parameter logic [31:0] CTRL_WMASK = 32'h0000_3F8F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_ttb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] ttb_q
);
    localparam logic [DATA_W-1:0] WMASK = DATA_W'(CTRL_WMASK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ttb_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata & WMASK;
            if (wr_ttb)  ttb_q  <= wdata;
        end
    end

    assert_ctrl_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ((ctrl_q & ~WMASK) == '0) && ((ctrl_q ^ $past(wdata)) & WMASK) == '0);
    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q));
    assert_ttb_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ttb |=> ttb_q == $past(wdata));
    assert_ttb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ttb |=> $stable(ttb_q));
endmodule

// File: rtl/cpx_access.sv
module cpx_access
    import cpx_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter logic [31:0] ID_VALUE   = 32'h6905_2100,
    parameter logic [31:0] CTRL_WMASK = 32'h0000_3F8F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cycle_count,
    input  logic              ext_en,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              err,
    output logic              mmu_on,
    output logic [DATA_W-1:0] table_base
);
    cpx_state_e        state_q, state_d;
    logic              fault, sys_sel;
    logic [3:0]        crn;
    logic [DATA_W-1:0] rd_value, ctrl_q, ttb_q, rdata_q;
    logic              wr_ctrl, wr_ttb;

    cpx_decode #(.DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_decode (
        .insn        (insn),
        .ext_en      (ext_en),
        .ctrl_q      (ctrl_q),
        .ttb_q       (ttb_q),
        .cycle_count (cycle_count),
        .fault       (fault),
        .sys_sel     (sys_sel),
        .crn         (crn),
        .rd_value    (rd_value)
    );

    assign wr_ctrl = req && wr && sys_sel && (crn == RN_CTRL);
    assign wr_ttb  = req && wr && sys_sel && (crn == RN_TTB);

    cpx_regfile #(.DATA_W(DATA_W), .CTRL_WMASK(CTRL_WMASK)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_ttb  (wr_ttb),
        .wdata   (wdata),
        .ctrl_q  (ctrl_q),
        .ttb_q   (ttb_q)
    );

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ACK, ST_FAULT: begin
                if (req) state_d = fault ? ST_FAULT : ST_ACK;
                else     state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     rdata_q <= '0;
        else if (req && !wr && !fault)  rdata_q <= rd_value;
        else                            rdata_q <= '0;
    end

    always_comb begin
        done       = (state_q == ST_ACK);
        err        = (state_q == ST_FAULT);
        rdata      = rdata_q;
        mmu_on     = ctrl_q[0];
        table_base = ttb_q;
    end

    assert_resp_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (done ^ err));
    assert_quiet_after_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!done && !err && rdata == '0));
    assert_fault_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rdata == '0) && $stable(table_base) && $stable(mmu_on));
    assert_ctrl_fixed_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && insn[11:8] == 4'd15 && insn[19:16] == 4'd1) |=> (rdata[6:4] == 3'b111));
endmodule

// File: tb/cpx_access_bench.sv
module cpx_access_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] ID_V       = 32'h6905_2100;
    localparam logic [31:0] MASK       = 32'h0000_3F8F;

    logic        clk = 1'b0;
    logic        rst_n, req, wr, ext_en;
    logic [31:0] insn, wdata, cycle_count, rdata, table_base;
    logic        done, err, mmu_on;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_ctrl, m_ttb, e_rdata;
    logic        e_done, e_err;
    string       e_tag;

    cpx_access #(.ID_VALUE(ID_V), .CTRL_WMASK(MASK)) u_cpx_access (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .insn(insn),
        .wdata(wdata), .cycle_count(cycle_count), .ext_en(ext_en),
        .rdata(rdata), .done(done), .err(err), .mmu_on(mmu_on),
        .table_base(table_base)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial cycle_count = 32'h1234_0000;
    always @(posedge clk) cycle_count <= cycle_count + 32'd1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // set inputs at a negedge; compute the expected response and model update
    task automatic drive(input bit w, input logic [3:0] cp, input logic [3:0] rn,
                         input logic [31:0] d, input bit x);
        logic ok;
        req    = 1'b1;
        wr     = w;
        ext_en = x;
        wdata  = d;
        insn   = {~d[31:20], rn, d[7:4] ^ 4'h5, cp, d[15:8] ^ {rn, cp}};
        ok     = (cp == 4'd15) || (cp == 4'd14 && x);
        e_done = ok;
        e_err  = !ok;
        e_rdata = 32'h0;
        if (!ok) e_tag = "R9";
        else if (cp == 4'd15) begin
            case (rn)
                4'd0: e_tag = "R5";
                4'd1: e_tag = "R3";
                4'd2: e_tag = "R4";
                default: e_tag = w ? "R6" : "R5";
            endcase
            if (!w) begin
                if (rn == 4'd0)      e_rdata = ID_V;
                else if (rn == 4'd1) e_rdata = m_ctrl | 32'h70;
                else if (rn == 4'd2) e_rdata = m_ttb;
            end else begin
                if (rn == 4'd1) m_ctrl = d & MASK;
                if (rn == 4'd2) m_ttb  = d;
            end
        end else begin
            e_tag = w ? "R8" : "R7";
            if (!w && rn == 4'd1) e_rdata = cycle_count;
        end
    endtask

    task automatic check_resp();
        chk({e_tag, "/R10 done"}, {31'b0, done}, {31'b0, e_done});
        chk({e_tag, "/R10 err"},  {31'b0, err},  {31'b0, e_err});
        chk({e_tag, "/R1 rdata"}, rdata, e_rdata);
        chk({e_tag, " mmu_on"},   {31'b0, mmu_on}, {31'b0, m_ctrl[0]});
        chk({e_tag, " table_base"}, table_base, m_ttb);
    endtask

    task automatic access(input bit w, input logic [3:0] cp, input logic [3:0] rn,
                          input logic [31:0] d, input bit x);
        @(negedge clk);
        drive(w, cp, rn, d, x);
        @(negedge clk);
        check_resp();
        req = 1'b0;
        @(negedge clk);
        chk("R10 idle done", {31'b0, done}, 32'h0);
        chk("R10 idle err",  {31'b0, err},  32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req = 1'b0; wr = 1'b0; ext_en = 1'b0;
        insn = '0; wdata = '0;
        m_ctrl = '0; m_ttb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 done",       {31'b0, done},   32'h0);
        chk("R2 err",        {31'b0, err},    32'h0);
        chk("R2 rdata",      rdata,           32'h0);
        chk("R2 mmu_on",     {31'b0, mmu_on}, 32'h0);
        chk("R2 table_base", table_base,      32'h0);
        access(1'b0, 4'd15, 4'd1, 32'h0, 1'b0);   // R3: reset control reads 0x70

        // R3/R6: control write, then maintenance writes, then read back
        access(1'b1, 4'd15, 4'd1, 32'hFFFF_FFFF, 1'b0);
        access(1'b1, 4'd15, 4'd7, 32'h0000_0000, 1'b0);
        access(1'b1, 4'd15, 4'd8, 32'h0000_0000, 1'b0);
        access(1'b0, 4'd15, 4'd1, 32'h0, 1'b0);
        access(1'b1, 4'd15, 4'd1, 32'h0000_0072, 1'b0);
        access(1'b0, 4'd15, 4'd1, 32'h0, 1'b0);

        // R10: back-to-back requests
        @(negedge clk);
        drive(1'b1, 4'd15, 4'd2, 32'hCAFE_4000, 1'b1);
        @(negedge clk);
        check_resp();
        drive(1'b0, 4'd14, 4'd1, 32'h0, 1'b1);
        @(negedge clk);
        check_resp();
        drive(1'b0, 4'd3, 4'd1, 32'h0, 1'b1);
        @(negedge clk);
        check_resp();
        req = 1'b0;

        // R1/R5/R7/R8/R9: sweep every coprocessor and register, both ext settings
        for (int x = 0; x < 2; x++)
            for (int cp = 0; cp < 16; cp++)
                for (int rn = 0; rn < 16; rn++) begin
                    access(1'b1, 4'(cp), 4'(rn),
                           {4'(rn), 4'(cp), 8'(x * 37 + cp * 11), 16'hA5C3 ^ 16'(rn * 1237)}, bit'(x));
                    access(1'b0, 4'(cp), 4'(rn), 32'h0, bit'(x));
                end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule